// File: doc/BRIEF.md
# Configurable UART Transmitter

This block turns queued characters into an asynchronous serial stream. Characters enter through a write port into a small transmit queue. A frame engine takes one character at a time and sends a start bit, then 6, 7 or 8 data bits with the least significant bit first, then an optional parity bit, then 1, 1.5 or 2 stop bits. Every bit time is 16 pulses of an external oversample enable (`baud_tick`). The character length, the parity kind and the stop length come from a packed mode word. The engine reads the mode word when it takes a character from the queue, so a mode change never alters a frame already on the line.

A command word carries one-hot bits. These bits enable or disable the transmitter, reset it, and start or stop a break. The transmitter reports queue empty, full and nearly full, a transmitter-active flag and a one-cycle overflow event. The frame engine is a state machine with five states. ST_IDLE moves to ST_START when the transmitter is enabled, no break is held and the queue is not empty. ST_START moves to ST_DATA after 16 ticks. ST_DATA moves to ST_PARITY, or to ST_STOP when parity is off, after the last data bit. ST_PARITY moves to ST_STOP after 16 ticks. ST_STOP returns to ST_IDLE once the stop length has run out. A transmitter reset command sends any state back to ST_IDLE in the next cycle.

Top module: `uart_char_tx`

## Requirements
- R1: After reset `txd` is 1, `fifo_empty` is 1, `fifo_full`, `fifo_near_full`, `tx_active` and `tx_overflow` are 0, and the transmitter is disabled. A character written while disabled stays queued and is not sent.
- R2: A frame is a low start bit, the data bits least significant first, the optional parity bit, and high stop bits. Each bit lasts exactly 16 `baud_tick` pulses.
- R3: Mode bits [2:1] set the character length: 00 or 01 gives 8 bits, 10 gives 7 bits, 11 gives 6 bits. Only the low bits of the written byte are sent.
- R4: Mode bits [5:3] set the parity. 000 is even (the ones in data plus parity are even), 001 is odd, 010 always sends 0, 011 always sends 1, and 1xx sends no parity bit.
- R5: Mode bits [7:6] set the stop length: 00 gives 16 ticks, 01 gives 24 ticks, 10 gives 32 ticks, and 11 is treated as 16 ticks.
- R6: With a queue depth of 8, `fifo_empty` means 0 entries, `fifo_full` means 8 entries, and `fifo_near_full` means at least 6 entries.
- R7: A write to a full queue is dropped, and `tx_overflow` is high for the one cycle after the clock edge that saw the write. The characters already queued are still sent in order.
- R8: A command takes effect when `cmd_valid` is high. Bit 4 enables the transmitter and bit 5 disables it. If both bits are set, the transmitter ends up disabled. Bits 0, 2 and 3 have no effect on the transmitter.
- R9: Disabling the transmitter during a frame lets that frame finish. No further character starts.
- R10: Command bit 7 forces `txd` low from the next cycle until command bit 8 arrives. If both bits are set, the break is released. No character starts while the break is held.
- R11: Command bit 1 empties the queue and abandons the current frame. From the next cycle `tx_active` is 0 and `txd` is 1. The enable state is kept.
- R12: `tx_active` is 1 exactly while a frame is being sent. For one frame it stays high for 16*(1+data+parity) ticks plus the stop length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_word | input | 8 | Packed frame format: length [2:1], parity [5:3], stop [7:6] |
| baud_tick | input | 1 | Oversample enable, 16 pulses per bit |
| cmd_valid | input | 1 | Command word is valid this cycle |
| cmd_word | input | 9 | One-hot command bits |
| wr_valid | input | 1 | Write a character into the queue |
| wr_data | input | 8 | Character to queue |
| txd | output | 1 | Serial output, idles high |
| fifo_empty | output | 1 | Queue holds no characters |
| fifo_full | output | 1 | Queue is full |
| fifo_near_full | output | 1 | Queue has at least depth minus 2 entries |
| tx_active | output | 1 | A frame is being sent |
| tx_overflow | output | 1 | One-cycle pulse after a dropped write |

## Verification
Each test sends a frame and samples `txd` in the middle of every bit slot. It also measures how many ticks `tx_active` stays high. A wrong tick count or bit index therefore appears within the same frame, either as a bit in the wrong slot or as a frame of the wrong length. A wrong queue pointer or count appears at the first write or read that uses it, as a wrong flag right after the write or as a wrong or missing character in the next frame. A wrong enable or break register shows up one cycle after the command: `txd` has the wrong level, or the transmitter starts or fails to start a character.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int MODE_W      = 8;
    localparam int CHAR_W      = 8;
    localparam int CMD_W       = 9;

    localparam int CMD_TX_RST  = 1;
    localparam int CMD_TX_EN   = 4;
    localparam int CMD_TX_DIS  = 5;
    localparam int CMD_BRK_ON  = 7;
    localparam int CMD_BRK_OFF = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    typedef enum logic [1:0] {
        PK_EVEN,
        PK_ODD,
        PK_SPACE,
        PK_MARK
    } par_kind_e;

    typedef enum logic [1:0] {
        SB_ONE,
        SB_ONE_HALF,
        SB_TWO
    } stop_len_e;

    typedef struct packed {
        logic [3:0] nbits;
        logic       par_on;
        par_kind_e  par_kind;
        stop_len_e  stop_len;
    } frame_cfg_t;

    // Fields of the mode word; bit 0 is not part of the frame format.
    function automatic frame_cfg_t decode_mode(input logic [MODE_W-1:1] m);
        frame_cfg_t c;
        if (!m[2])      c.nbits = 4'd8;
        else if (!m[1]) c.nbits = 4'd7;
        else            c.nbits = 4'd6;
        c.par_on   = !m[5];
        c.par_kind = par_kind_e'(m[4:3]);
        unique case (m[7:6])
            2'b01:   c.stop_len = SB_ONE_HALF;
            2'b10:   c.stop_len = SB_TWO;
            default: c.stop_len = SB_ONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/uart_tx_cmd.sv
module uart_tx_cmd
    import uart_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_word,
    output logic             tx_en,
    output logic             brk_on,
    output logic             tx_flush
);

    logic tx_en_q;
    logic brk_q;
    logic cmd_unused;

    // Receiver and reserved bits are accepted but have no effect here.
    assign cmd_unused = ^{cmd_word[0], cmd_word[2], cmd_word[3], cmd_word[6]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_en_q <= 1'b0;
            brk_q   <= 1'b0;
        end else if (cmd_valid) begin
            if (cmd_word[CMD_TX_DIS])      tx_en_q <= 1'b0;
            else if (cmd_word[CMD_TX_EN])  tx_en_q <= 1'b1;
            if (cmd_word[CMD_BRK_OFF])     brk_q   <= 1'b0;
            else if (cmd_word[CMD_BRK_ON]) brk_q   <= 1'b1;
        end
    end

    always_comb begin
        tx_en    = tx_en_q;
        brk_on   = brk_q;
        tx_flush = cmd_valid && cmd_word[CMD_TX_RST];
    end

    AST_DIS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_word[CMD_TX_DIS]) |=> !tx_en);  // R8

    AST_BRK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_word[CMD_BRK_OFF]) |=> !brk_on);  // R10

endmodule

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
    parameter int DEPTH    = 8,
    parameter int NEAR_GAP = 2,
    parameter int W        = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         full,
    output logic         near_full,
    output logic         ovf
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem_q [DEPTH];
    logic [AW-1:0] wr_ptr_q;
    logic [AW-1:0] rd_ptr_q;
    logic [CW-1:0] cnt_q;
    logic          ovf_q;
    logic          push;
    logic          pop;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        push = wr_en && !full && !flush;
        pop  = rd_en && !empty && !flush;
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[wr_ptr_q] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
            ovf_q    <= 1'b0;
        end else begin
            ovf_q <= wr_en && full;
            if (flush) begin
                wr_ptr_q <= '0;
                rd_ptr_q <= '0;
                cnt_q    <= '0;
            end else begin
                if (push) wr_ptr_q <= ptr_next(wr_ptr_q);
                if (pop)  rd_ptr_q <= ptr_next(rd_ptr_q);
                unique case ({push, pop})
                    2'b10:   cnt_q <= cnt_q + CW'(1);
                    2'b01:   cnt_q <= cnt_q - CW'(1);
                    default: cnt_q <= cnt_q;
                endcase
            end
        end
    end

    always_comb begin
        rd_data   = mem_q[rd_ptr_q];
        empty     = (cnt_q == '0);
        full      = (cnt_q == CW'(DEPTH));
        near_full = (cnt_q >= CW'(DEPTH - NEAR_GAP));
        ovf       = ovf_q;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !rd_en && !flush) |=> $stable(cnt_q));  // R7

    AST_OVF_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full) |=> ovf);  // R7

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full));  // R6

endmodule

// File: rtl/uart_tx_serializer.sv
module uart_tx_serializer
    import uart_tx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              go_ok,
    input  logic              tick,
    input  logic [MODE_W-1:0] mode_word,
    input  logic              fifo_empty,
    input  logic [CHAR_W-1:0] fifo_data,
    output logic              pop,
    output logic              line_bit,
    output logic              active
);

    localparam int CNT_W = $clog2(2 * OVS);
    localparam int IDX_W = $clog2(CHAR_W);
    localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(OVS - 1);
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OVS + OVS / 2 - 1);
    localparam logic [CNT_W-1:0] TWO_LAST  = CNT_W'(2 * OVS - 1);

    tx_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic [CHAR_W-1:0] sh_q, sh_d;
    logic              par_q, par_d;
    frame_cfg_t        cfg_q, cfg_d;

    frame_cfg_t        cfg_new;
    logic [CHAR_W-1:0] len_mask;
    logic [CHAR_W-1:0] masked;
    logic              par_new;
    logic [CNT_W-1:0]  stop_last;
    logic              start_ok;
    logic              mode_unused;

    assign mode_unused = mode_word[0];

    // Format and parity of the next character, fixed at load time.
    always_comb begin
        cfg_new  = decode_mode(mode_word[MODE_W-1:1]);
        len_mask = {CHAR_W{1'b1}} >> (4'd8 - cfg_new.nbits);
        masked   = fifo_data & len_mask;
        unique case (cfg_new.par_kind)
            PK_EVEN:  par_new = ^masked;
            PK_ODD:   par_new = ~^masked;
            PK_SPACE: par_new = 1'b0;
            default:  par_new = 1'b1;
        endcase
        unique case (cfg_q.stop_len)
            SB_ONE_HALF: stop_last = HALF_LAST;
            SB_TWO:      stop_last = TWO_LAST;
            default:     stop_last = BIT_LAST;
        endcase
        start_ok = (state_q == ST_IDLE) && go_ok && !fifo_empty && !abort;
    end

    // Next state and datapath.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        idx_d   = idx_q;
        sh_d    = sh_q;
        par_d   = par_q;
        cfg_d   = cfg_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_ok) begin
                    state_d = ST_START;
                    cnt_d   = '0;
                    idx_d   = '0;
                    sh_d    = fifo_data;
                    par_d   = par_new;
                    cfg_d   = cfg_new;
                end
            end
            ST_START: begin
                if (tick) begin
                    if (cnt_q == BIT_LAST) begin
                        cnt_d   = '0;
                        state_d = ST_DATA;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
            end
            ST_DATA: begin
                if (tick) begin
                    if (cnt_q == BIT_LAST) begin
                        cnt_d = '0;
                        sh_d  = sh_q >> 1;
                        if ({1'b0, idx_q} == cfg_q.nbits - 4'd1) begin
                            state_d = cfg_q.par_on ? ST_PARITY : ST_STOP;
                        end else begin
                            idx_d = idx_q + IDX_W'(1);
                        end
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
            end
            ST_PARITY: begin
                if (tick) begin
                    if (cnt_q == BIT_LAST) begin
                        cnt_d   = '0;
                        state_d = ST_STOP;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
            end
            ST_STOP: begin
                if (tick) begin
                    if (cnt_q == stop_last) begin
                        cnt_d   = '0;
                        state_d = ST_IDLE;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (abort) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            sh_q    <= '0;
            par_q   <= 1'b0;
            cfg_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            idx_q   <= idx_d;
            sh_q    <= sh_d;
            par_q   <= par_d;
            cfg_q   <= cfg_d;
        end
    end

    // Outputs.
    always_comb begin
        pop    = start_ok;
        active = (state_q != ST_IDLE);
        unique case (state_q)
            ST_START:  line_bit = 1'b0;
            ST_DATA:   line_bit = sh_q[0];
            ST_PARITY: line_bit = par_q;
            default:   line_bit = 1'b1;
        endcase
    end

    AST_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !abort && state_q != ST_IDLE) |=> $stable(state_q));  // R2

    AST_POP_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> (state_q == ST_START));  // R2

endmodule

// File: rtl/uart_char_tx.sv
module uart_char_tx
    import uart_tx_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int NEAR_GAP   = 2,
    parameter int OVS        = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_word,
    input  logic              baud_tick,
    input  logic              cmd_valid,
    input  logic [CMD_W-1:0]  cmd_word,
    input  logic              wr_valid,
    input  logic [CHAR_W-1:0] wr_data,
    output logic              txd,
    output logic              fifo_empty,
    output logic              fifo_full,
    output logic              fifo_near_full,
    output logic              tx_active,
    output logic              tx_overflow
);

    logic              tx_en;
    logic              brk_on;
    logic              tx_flush;
    logic              pop;
    logic [CHAR_W-1:0] head;
    logic              line_bit;

    uart_tx_cmd u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_valid(cmd_valid),
        .cmd_word (cmd_word),
        .tx_en    (tx_en),
        .brk_on   (brk_on),
        .tx_flush (tx_flush)
    );

    uart_tx_fifo #(
        .DEPTH   (FIFO_DEPTH),
        .NEAR_GAP(NEAR_GAP),
        .W       (CHAR_W)
    ) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (tx_flush),
        .wr_en    (wr_valid),
        .wr_data  (wr_data),
        .rd_en    (pop),
        .rd_data  (head),
        .empty    (fifo_empty),
        .full     (fifo_full),
        .near_full(fifo_near_full),
        .ovf      (tx_overflow)
    );

    uart_tx_serializer #(
        .OVS(OVS)
    ) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .abort     (tx_flush),
        .go_ok     (tx_en && !brk_on),
        .tick      (baud_tick),
        .mode_word (mode_word),
        .fifo_empty(fifo_empty),
        .fifo_data (head),
        .pop       (pop),
        .line_bit  (line_bit),
        .active    (tx_active)
    );

    always_comb begin
        txd = brk_on ? 1'b0 : line_bit;
    end

    AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_word[CMD_BRK_ON] && !cmd_word[CMD_BRK_OFF]) |=> !txd);  // R10

    AST_RESET_ABANDON: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_word[CMD_TX_RST]) |=> (!tx_active && fifo_empty));  // R11

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_active && !brk_on) |-> txd);  // R12

endmodule

// File: tb/uart_char_tx_tb.sv
module uart_char_tx_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] mode_word = 8'h20;
    logic       baud_tick = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [8:0] cmd_word = '0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic       txd, fifo_empty, fifo_full, fifo_near_full, tx_active, tx_overflow;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [8:0] C_TXRST = 9'h002;
    localparam logic [8:0] C_EN    = 9'h010;
    localparam logic [8:0] C_DIS   = 9'h020;
    localparam logic [8:0] C_BRK   = 9'h080;
    localparam logic [8:0] C_NOBRK = 9'h100;

    uart_char_tx u_dut (
        .clk(clk), .rst_n(rst_n), .mode_word(mode_word), .baud_tick(baud_tick),
        .cmd_valid(cmd_valid), .cmd_word(cmd_word), .wr_valid(wr_valid),
        .wr_data(wr_data), .txd(txd), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
        .fifo_near_full(fifo_near_full), .tx_active(tx_active), .tx_overflow(tx_overflow)
    );

    always #2 clk = ~clk;

    // One tick every 4 clocks, changed just after the rising edge.
    initial begin
        forever begin
            repeat (3) @(posedge clk);
            #1 baud_tick = 1'b1;
            @(posedge clk);
            #1 baud_tick = 1'b0;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog all act=timeout exp=done");
        finish_up();
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_cmd(input logic [8:0] w);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = w;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_word  = '0;
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = b;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    // Samples txd mid-slot and counts ticks while tx_active is high.
    task automatic capture(output int total, output logic [15:0] sm);
        int cons = 0;
        int guard = 0;
        sm = '1;
        @(negedge clk);
        while (!tx_active && guard < 4000) begin
            @(negedge clk);
            guard++;
        end
        while (tx_active) begin
            if (baud_tick && (cons % 16) == 8) sm[cons / 16] = txd;
            if (baud_tick) cons++;
            @(negedge clk);
        end
        total = cons;
    endtask

    task automatic frame_check(input string req, input logic [7:0] mode, input logic [7:0] d);
        int n, pon, st, tot, nslots;
        logic [7:0]  masked;
        logic        par;
        logic [15:0] ev, sm, m;
        n   = !mode[2] ? 8 : (!mode[1] ? 7 : 6);
        pon = mode[5] ? 0 : 1;
        st  = (mode[7:6] == 2'b01) ? 24 : ((mode[7:6] == 2'b10) ? 32 : 16);
        masked = d & (8'hFF >> (8 - n));
        unique case (mode[4:3])
            2'b00:   par = ^masked;
            2'b01:   par = ~^masked;
            2'b10:   par = 1'b0;
            default: par = 1'b1;
        endcase
        ev = '1;
        ev[0] = 1'b0;
        for (int i = 0; i < n; i++) ev[1 + i] = masked[i];
        if (pon == 1) ev[1 + n] = par;
        nslots = 2 + n + pon;
        m = 16'((32'd1 << nslots) - 1);
        @(negedge clk);
        mode_word = mode;
        push(d);
        capture(tot, sm);
        chk(req, "frame bits", 32'(sm & m), 32'(ev & m));
        chk("R12", "frame ticks", tot, 16 * (1 + n + pon) + st);
    endtask

    task automatic t_reset();
        chk("R1", "txd", 32'(txd), 1);
        chk("R1", "empty", 32'(fifo_empty), 1);
        chk("R1", "full", 32'(fifo_full), 0);
        chk("R1", "near_full", 32'(fifo_near_full), 0);
        chk("R1", "active", 32'(tx_active), 0);
        chk("R1", "overflow", 32'(tx_overflow), 0);
    endtask

    task automatic t_disabled_and_rx_bits();
        push(8'h55);
        wait_cyc(300);
        chk("R1", "no send while disabled", 32'(tx_active), 0);
        chk("R1", "char kept", 32'(fifo_empty), 0);
        send_cmd(9'h00D); // receiver reset/enable/disable bits: R8 says no effect
        wait_cyc(300);
        chk("R8", "rx bits ignored active", 32'(tx_active), 0);
        chk("R8", "rx bits ignored queue", 32'(fifo_empty), 0);
        send_cmd(C_TXRST);
        chk("R11", "flush while idle", 32'(fifo_empty), 1);
    endtask

    task automatic t_formats();
        send_cmd(C_EN);
        frame_check("R2", 8'h20, 8'hA5);
        frame_check("R3", 8'h04, 8'h35);  // 7 bits even parity
        frame_check("R3", 8'h0E, 8'hFB);  // 6 bits odd parity
        frame_check("R3", 8'h22, 8'h96);  // length code 01 = 8 bits
        frame_check("R4", 8'h10, 8'hFF);  // space parity
        frame_check("R4", 8'h18, 8'h00);  // mark parity
        frame_check("R4", 8'h08, 8'h81);  // odd, 8 bits
        frame_check("R4", 8'h30, 8'h3C);  // 110 = no parity
        frame_check("R5", 8'hA0, 8'h3C);  // 2 stop
        frame_check("R5", 8'h60, 8'hC3);  // 1.5 stop
        frame_check("R5", 8'hE0, 8'h5A);  // reserved = 1 stop
    endtask

    task automatic t_fifo();
        int tot;
        logic [15:0] sm;
        send_cmd(C_DIS);
        mode_word = 8'h20;
        for (int i = 0; i < 5; i++) push(8'h10 + 8'(i));
        chk("R6", "near_full at 5", 32'(fifo_near_full), 0);
        push(8'h15);
        chk("R6", "near_full at 6", 32'(fifo_near_full), 1);
        chk("R6", "full at 6", 32'(fifo_full), 0);
        push(8'h16);
        push(8'h17);
        chk("R6", "full at 8", 32'(fifo_full), 1);
        chk("R7", "no overflow yet", 32'(tx_overflow), 0);
        push(8'hEE);
        chk("R7", "overflow pulse", 32'(tx_overflow), 1);
        wait_cyc(1);
        chk("R7", "overflow one cycle", 32'(tx_overflow), 0);
        send_cmd(C_EN);
        for (int i = 0; i < 8; i++) begin
            capture(tot, sm);
            chk("R7", "queued char", 32'(sm[8:1]), 32'(8'h10 + 8'(i)));
        end
        wait_cyc(300);
        chk("R7", "dropped char not sent", 32'(tx_active), 0);
        chk("R6", "empty after drain", 32'(fifo_empty), 1);
    endtask

    task automatic t_en_dis_same();
        send_cmd(C_DIS);
        push(8'h77);
        send_cmd(C_EN | C_DIS);
        wait_cyc(300);
        chk("R8", "disable wins", 32'(tx_active), 0);
        send_cmd(C_TXRST);
    endtask

    task automatic t_disable_mid();
        int tot;
        logic [15:0] sm;
        send_cmd(C_EN);
        mode_word = 8'h20;
        push(8'hC9);
        push(8'h12);
        fork
            capture(tot, sm);
            begin
                wait_cyc(100);
                send_cmd(C_DIS);
            end
        join
        chk("R9", "frame finishes", 32'(sm[9:0]), 32'({1'b1, 8'hC9, 1'b0}));
        chk("R9", "frame length", tot, 160);
        wait_cyc(300);
        chk("R9", "no next start", 32'(tx_active), 0);
        chk("R9", "next still queued", 32'(fifo_empty), 0);
        send_cmd(C_TXRST);
    endtask

    task automatic t_break();
        send_cmd(C_EN);
        send_cmd(C_BRK);
        chk("R10", "break low", 32'(txd), 0);
        push(8'h42);
        wait_cyc(200);
        chk("R10", "no start in break", 32'(tx_active), 0);
        chk("R10", "still low", 32'(txd), 0);
        send_cmd(C_TXRST);
        send_cmd(C_NOBRK);
        chk("R10", "break released", 32'(txd), 1);
        send_cmd(C_BRK);
        send_cmd(C_BRK | C_NOBRK);
        chk("R10", "release wins", 32'(txd), 1);
    endtask

    task automatic t_tx_reset();
        send_cmd(C_EN);
        mode_word = 8'h20;
        push(8'hA1);
        push(8'hA2);
        push(8'hA3);
        wait_cyc(50);
        chk("R11", "busy before reset", 32'(tx_active), 1);
        send_cmd(C_TXRST);
        chk("R11", "active cleared", 32'(tx_active), 0);
        chk("R11", "queue emptied", 32'(fifo_empty), 1);
        chk("R11", "line high", 32'(txd), 1);
        frame_check("R11", 8'h20, 8'h6B);
    endtask

    initial begin
        wait_cyc(5);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        wait_cyc(2);
        t_reset();
        t_disabled_and_rx_bits();
        t_formats();
        t_fifo();
        t_en_dis_same();
        t_disable_mid();
        t_break();
        t_tx_reset();
        finish_up();
    end

endmodule